// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Block Read Controller

This block models main memory for cache refills. Every request names one four-word block. The block's words are spread over four banks, one word per bank. A single request starts an access in all four banks together. The four 32-bit words then return one after another over a single 32-bit response bus. Each word carries its index within the block, and the final word also carries an end-of-block flag.

The bank that holds a word is picked by the word's position in the block, which is byte-address bits 3..2. The row inside each bank is the block address. Bank contents are a fixed pattern that is loaded while reset is asserted.

A parameter selects a non-overlapped mode in which each word needs its own full access before it is transferred. This mode allows the interleaved timing to be compared against a plain single-bank organisation. The controller accepts a new block address only when it is idle.

Top module: `interleaved_mem_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only at a rising edge where both `req_valid` and `req_ready` are 1. A `req_valid` presented while `req_ready` is 0 has no effect: it does not change the burst in progress, and it does not start a later burst.
- R3: With `SEQUENTIAL`=0, word k (k = 0..3) is on the bus for exactly one cycle, beginning 11+k rising edges after the accepting edge. This is 1 address cycle, then 10 parallel access cycles, then one transfer cycle per word, so the block completes 15 cycles after acceptance.
- R4: With `SEQUENTIAL`=1, word k is on the bus for one cycle, beginning 11+11k edges after the accepting edge. Each word gets its own 10-cycle access and 1 transfer cycle, so the block completes 45 cycles after acceptance.
- R5: Words leave in ascending index order 0, 1, 2, 3, and `rsp_idx` gives the index of the word currently on the bus.
- R6: `rsp_last` is 1 only together with the word whose index is 3.
- R7: Word k of block b comes from bank k, row b, and its value is {6'b101000, k[1:0], 8'h3C, b zero-extended to 16 bits}, which is hex A03C0000 + k·0x01000000 + b.
- R8: `req_ready` is 0 from the accepting edge until the final word has been transferred. It returns to 1 in the cycle after the final word: 15 edges after acceptance when interleaved, 45 edges when sequential.
- R9: `rsp_data` and `rsp_last` are 0 in every cycle in which `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; also loads the bank contents |
| req_valid | input | 1 | Block read request |
| req_ready | output | 1 | Controller is idle and will take a request |
| req_addr | input | ADDR_W | Block address; used as the row in every bank |
| rsp_valid | output | 1 | A data word is on the response bus |
| rsp_data | output | 32 | Response data word |
| rsp_idx | output | 2 | Index of the word within its block |
| rsp_last | output | 1 | Final word of the block |

## Verification
A miscounted access counter moves every word by whole cycles. The first word then appears early or late relative to the 11-edge point, and this is visible at the first response of the first burst. A word index that skips or repeats shows up as a wrong tag or a wrong bank word on the very next transfer cycle. A controller that leaves its idle state at the wrong moment shows up in `req_ready`, or as a spurious burst a few cycles after a request that should have been ignored. Because both modes run from the same stimulus, a wrong choice between the one-access-per-block path and the one-access-per-word path is caught at word 1, which is the first point where the two modes diverge.

// File: rtl/interleaved_mem_ctrl.sv
module interleaved_mem_ctrl #(
  parameter int ADDR_W     = 4,
  parameter int ACCESS_CYC = 10,
  parameter bit SEQUENTIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [1:0]        rsp_idx,
  output logic              rsp_last
);
  localparam int NBANK = 4;
  localparam int ROWS  = 1 << ADDR_W;
  localparam int CW    = $clog2(ACCESS_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACC, S_XFER} st_t;

  st_t               state;
  logic [CW-1:0]     cnt;
  logic [1:0]        widx;
  logic [ADDR_W-1:0] row;
  logic [31:0]       mem [NBANK][ROWS];
  logic [31:0]       lat [NBANK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      widx  <= '0;
      row   <= '0;
      for (int b = 0; b < NBANK; b++) begin
        lat[b] <= '0;
        for (int r = 0; r < ROWS; r++)
          mem[b][r] <= {6'b101000, 2'(b), 8'h3C, 16'(r)};
      end
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          row   <= req_addr;
          widx  <= '0;
          state <= S_ADDR;
        end
        S_ADDR: begin
          cnt   <= CW'(ACCESS_CYC - 1);
          state <= S_ACC;
        end
        S_ACC: if (cnt == '0) begin
          state <= S_XFER;
          if (SEQUENTIAL)
            lat[widx] <= mem[widx][row];
          else
            for (int b = 0; b < NBANK; b++) lat[b] <= mem[b][row];
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_XFER: if (widx == 2'd3) begin
          state <= S_IDLE;
        end else begin
          widx <= widx + 1'b1;
          if (SEQUENTIAL) begin
            cnt   <= CW'(ACCESS_CYC - 1);
            state <= S_ACC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_XFER);
  assign rsp_idx   = widx;
  assign rsp_last  = rsp_valid && (widx == 2'd3);
  assign rsp_data  = rsp_valid ? lat[widx] : 32'h0;

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !rsp_valid);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  p_last_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid && rsp_idx == 2'd3);
  p_ready_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> req_ready && !rsp_valid);
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_data == 32'h0 && !rsp_last);

  generate
    if (SEQUENTIAL) begin : g_seq_chk
      p_gap_between_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |=> !rsp_valid && !req_ready);
    end else begin : g_int_chk
      p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |=> rsp_valid && rsp_idx == $past(rsp_idx) + 2'd1);
      p_first_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> rsp_idx == 2'd0);
    end
  endgenerate
endmodule

// File: tb/test_interleaved_mem_ctrl.sv
module test_interleaved_mem_ctrl;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rdy_i, vld_i, lst_i, rdy_s, vld_s, lst_s;
  logic [31:0] dat_i, dat_s;
  logic [1:0] idx_i, idx_s;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  interleaved_mem_ctrl #(.ADDR_W(ADDR_W), .ACCESS_CYC(10), .SEQUENTIAL(1'b0)) i_interleaved_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_i), .req_addr(req_addr),
    .rsp_valid(vld_i), .rsp_data(dat_i), .rsp_idx(idx_i), .rsp_last(lst_i));

  interleaved_mem_ctrl #(.ADDR_W(ADDR_W), .ACCESS_CYC(10), .SEQUENTIAL(1'b1)) i_interleaved_mem_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s), .req_addr(req_addr),
    .rsp_valid(vld_s), .rsp_data(dat_s), .rsp_idx(idx_s), .rsp_last(lst_s));

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] b, input int k);
    return 32'hA03C0000 + (32'(k) << 24) + 32'(b);
  endfunction

  function automatic int word_slot(input bit seq, input int k);
    return seq ? 11 + 11 * k : 11 + k;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic eval_cycle(input string tag, input bit seq, input int n,
                            input logic [ADDR_W-1:0] a, input logic rdy, input logic vld,
                            input logic lst, input logic [1:0] idx, input logic [31:0] d,
                            inout bit bad);
    int hit = -1;
    int done = seq ? 45 : 15;
    for (int k = 0; k < 4; k++) if (n == word_slot(seq, k)) hit = k;
    if (hit >= 0) begin
      logic [35:0] act = {vld, lst, idx, d};
      logic [35:0] exp = {1'b1, hit == 3, 2'(hit), exp_word(a, hit)};
      chk(act == exp, seq ? "R4 R5 R6 R7" : "R3 R5 R6 R7",
          $sformatf("%s word %0d blk %0d", tag, hit, a), 64'(act), 64'(exp));
    end else if (vld || lst || d != 32'h0) begin
      bad = 1'b1;
    end
    if (rdy != (n >= done)) bad = 1'b1;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input bit junk);
    bit bad_i = 1'b0;
    bit bad_s = 1'b0;
    bit quiet = 1'b1;
    @(negedge clk);
    chk(rdy_i && rdy_s, "R2", "idle before request", 64'({rdy_i, rdy_s}), 64'(2'b11));
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    for (int n = 0; n <= 45; n++) begin
      @(negedge clk);
      eval_cycle("int", 1'b0, n, a, rdy_i, vld_i, lst_i, idx_i, dat_i, bad_i);
      eval_cycle("seq", 1'b1, n, a, rdy_s, vld_s, lst_s, idx_s, dat_s, bad_s);
      if (junk && n < 10) begin
        req_valid = 1'b1;
        req_addr  = ~a;
      end else begin
        req_valid = 1'b0;
      end
    end
    chk(!bad_i, "R2 R8 R9", "interleaved ready/idle bus", 64'(bad_i), 64'(0));
    chk(!bad_s, "R2 R8 R9", "sequential ready/idle bus", 64'(bad_s), 64'(0));
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      if (vld_i || vld_s || !rdy_i || !rdy_s) quiet = 1'b0;
    end
    chk(quiet, "R2", "no burst after busy-time request", 64'(quiet), 64'(1));
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(rdy_i && rdy_s && !vld_i && !vld_s, "R1", "during reset",
        64'({rdy_i, rdy_s, vld_i, vld_s}), 64'(4'b1100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_i && rdy_s && !vld_i && !vld_s, "R1", "after reset",
        64'({rdy_i, rdy_s, vld_i, vld_s}), 64'(4'b1100));
    do_read(4'd0, 1'b0);
    do_read(4'd15, 1'b1);
    do_read(4'd5, 1'b0);
    do_read(4'd10, 1'b1);
    for (int i = 0; i < 6; i++)
      do_read(ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1)), 1'($urandom_range(0, 1)));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule